// File: doc/BRIEF.md
# Multiplexed Mains and Thermal Monitor

This block sequences one shared sense pin between two alternating measurement windows. In the mains window it reads two comparator flags that report whether the rectified mains level sits above the brown-in and the brown-out thresholds. In the thermal window it reads one flag that reports whether the thermistor voltage is still above its detection level. The analog front end (pin regulation, current source, clamp) lives elsewhere; this block sees only the comparator flags and a periodic phase tick.

Each detector applies its own persistence rule. Switching is permitted (`brownin_ok_o`) once a mains sample shows the level above brown-in. The brown-in threshold lies above the brown-out threshold, so a weaker reading that still clears brown-out keeps permission. A brown-out fires a one-cycle restart event only after the reading has stayed low for a full programmable span of ticks. An overtemperature latches off after a programmable number of back-to-back bad thermal samples. A strobe marks each cycle in which a fresh mains reading has been captured, so the offset-cancel and line-compensation logic downstream can take it.

Top module: `mains_thermal_monitor`

## Requirements
- R1: After reset (and while `rst_ni` is low) all four outputs are 0, and the first window after reset is a mains window.
- R2: Windows alternate mains, thermal, mains, ... and each lasts `WIN_TICKS` cycles with `tick_i` high. The comparator flags are sampled only in the cycle with the last tick of a window; values at any other time have no effect on the outputs.
- R3: `mains_valid_o` is high for exactly one cycle, the cycle after the last tick of each mains window, and never after a thermal window.
- R4: A mains sample with `mains_bi_i`=1 and `mains_bo_i`=1 sets `brownin_ok_o`; a sample with both flags low leaves it 0.
- R5: Once `brownin_ok_o` is 1, a mains sample with `mains_bi_i`=0 and `mains_bo_i`=1 keeps it at 1 (hysteresis).
- R6: While `brownin_ok_o` is 1, a mains sample with `mains_bo_i`=0 starts a low span. If no sample with `mains_bo_i`=1 arrives, `brownout_o` pulses for one cycle after the `BO_TICKS`-th following tick, and `brownin_ok_o` drops to 0 in that same cycle.
- R7: A mains sample with `mains_bo_i`=1 before the span expires cancels it; no `brownout_o` pulse follows from that span.
- R8: `OT_HITS` consecutive thermal samples with `therm_ok_i`=0 set `ot_latch_o`; a thermal sample with `therm_ok_i`=1 restarts the count from zero.
- R9: `ot_latch_o` stays 1 regardless of later thermal samples until reset.
- R10: All outputs are registered and change in the cycle after the tick that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Window-phase tick, one cycle wide |
| mains_bi_i | input | 1 | Mains reading above brown-in threshold |
| mains_bo_i | input | 1 | Mains reading above brown-out threshold |
| therm_ok_i | input | 1 | Thermistor voltage above detection level |
| brownin_ok_o | output | 1 | Switching permitted by mains level |
| brownout_o | output | 1 | One-cycle restart request on brown-out |
| ot_latch_o | output | 1 | Latched overtemperature |
| mains_valid_o | output | 1 | One-cycle strobe: stored mains reading updated |

## Verification
Every result is due in the cycle that follows the tick causing it: the sampling tick at the end of a window for the permission flag, the strobe and the thermal latch, and the expiring tick for the brown-out pulse, which can land inside a thermal window. The bench drives inputs on falling edges and samples one cycle after the closing tick of each window, while a monitor collects brown-out pulses across the whole window so a pulse is caught wherever it lands. Flags during the non-final ticks are driven to the inverse of the final value to show that they are ignored.

// File: rtl/monitor_pkg.sv
package monitor_pkg;
  typedef enum logic {PH_MAINS = 1'b0, PH_THERM = 1'b1} phase_e;
endpackage

// File: rtl/window_sequencer.sv
module window_sequencer #(
  parameter int WIN_TICKS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic mains_samp_o,
  output logic therm_samp_o
);
  import monitor_pkg::*;
  localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;
  phase_e        phase_q;
  logic          last_tick;

  assign last_tick    = tick_i && (cnt_q == LAST);
  assign mains_samp_o = last_tick && (phase_q == PH_MAINS);
  assign therm_samp_o = last_tick && (phase_q == PH_THERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_MAINS;
    end else if (tick_i) begin
      if (last_tick) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_MAINS) ? PH_THERM : PH_MAINS;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_one_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mains_samp_o, therm_samp_o}));
  assert_samp_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mains_samp_o || therm_samp_o) |-> tick_i);
  assert_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mains_samp_o |=> (phase_q == PH_THERM));
endmodule

// File: rtl/mains_detector.sv
module mains_detector #(
  parameter int BO_TICKS = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic samp_i,
  input  logic bi_i,
  input  logic bo_i,
  output logic brownin_ok_o,
  output logic brownout_o
);
  localparam int CW = (BO_TICKS > 1) ? $clog2(BO_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BO_TICKS - 1);

  logic          ok_q, low_q, bo_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      low_q <= 1'b0;
      bo_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      bo_q <= 1'b0;
      if (samp_i && bo_i) begin
        low_q <= 1'b0;
        cnt_q <= '0;
        if (bi_i) ok_q <= 1'b1;
      end else if (low_q && ok_q && tick_i) begin
        if (cnt_q == LAST) begin
          bo_q  <= 1'b1;
          ok_q  <= 1'b0;
          low_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (samp_i) begin
        // first low sample opens the span
        low_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign brownin_ok_o = ok_q;
  assign brownout_o   = bo_q;

  assert_bi_from_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> $past(samp_i && bi_i && bo_i));
  assert_bo_drops_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_o |-> !brownin_ok_o);
  assert_bo_needs_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_o |-> $past(ok_q));
  assert_bo_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_o |=> !brownout_o);
endmodule

// File: rtl/thermal_detector.sv
module thermal_detector #(
  parameter int OT_HITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_i,
  input  logic ok_i,
  output logic ot_o
);
  localparam int CW = (OT_HITS > 1) ? $clog2(OT_HITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OT_HITS - 1);

  logic [CW-1:0] hit_q;
  logic          ot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= '0;
      ot_q  <= 1'b0;
    end else if (samp_i && !ot_q) begin
      if (ok_i) begin
        hit_q <= '0;
      end else if (hit_q == LAST) begin
        ot_q <= 1'b1;
      end else begin
        hit_q <= hit_q + 1'b1;
      end
    end
  end

  assign ot_o = ot_q;

  assert_ot_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_q |=> ot_q);
  assert_ot_from_bad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ot_q) |-> $past(samp_i && !ok_i));
endmodule

// File: rtl/mains_thermal_monitor.sv
module mains_thermal_monitor #(
  parameter int WIN_TICKS = 500,
  parameter int BO_TICKS  = 32000,
  parameter int OT_HITS   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mains_bi_i,
  input  logic mains_bo_i,
  input  logic therm_ok_i,
  output logic brownin_ok_o,
  output logic brownout_o,
  output logic ot_latch_o,
  output logic mains_valid_o
);
  logic mains_samp, therm_samp, valid_q;

  window_sequencer #(.WIN_TICKS(WIN_TICKS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .mains_samp_o (mains_samp),
    .therm_samp_o (therm_samp)
  );

  mains_detector #(.BO_TICKS(BO_TICKS)) u_mains (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .samp_i       (mains_samp),
    .bi_i         (mains_bi_i),
    .bo_i         (mains_bo_i),
    .brownin_ok_o (brownin_ok_o),
    .brownout_o   (brownout_o)
  );

  thermal_detector #(.OT_HITS(OT_HITS)) u_therm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (therm_samp),
    .ok_i   (therm_ok_i),
    .ot_o   (ot_latch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= mains_samp;
  end

  assign mains_valid_o = valid_q;

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mains_valid_o |=> !mains_valid_o);
  assert_valid_after_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mains_valid_o |-> $past(tick_i));
endmodule

// File: tb/mains_thermal_monitor_tb.sv
module mains_thermal_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int BO = 12;
  localparam int OH = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bi = 1'b0, bo = 1'b0, tok = 1'b0;
  logic bi_ok, bo_ev, ot, valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  mains_thermal_monitor #(.WIN_TICKS(W), .BO_TICKS(BO), .OT_HITS(OH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .mains_bi_i(bi), .mains_bo_i(bo), .therm_ok_i(tok),
    .brownin_ok_o(bi_ok), .brownout_o(bo_ev), .ot_latch_o(ot), .mains_valid_o(valid)
  );

  typedef struct {
    logic biok, bo, ot, valid;
    string tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  logic check_req = 1'b0;
  logic bo_acc = 1'b0;

  // reference state, reset to R1 values
  logic m_phase = 1'b0, m_biok = 1'b0, m_low = 1'b0, m_ot = 1'b0, m_bo = 1'b0;
  int   m_cnt = 0, m_hit = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_tick(input logic last, input logic f_bi, input logic f_bo, input logic f_ok);
    logic sm, st;
    sm = last && !m_phase;
    st = last && m_phase;
    if (sm && f_bo) begin
      m_low = 0; m_cnt = 0;
      if (f_bi) m_biok = 1;
    end else if (m_low && m_biok) begin
      if (m_cnt == BO-1) begin
        m_bo = 1; m_biok = 0; m_low = 0; m_cnt = 0;
      end else m_cnt++;
    end else if (sm) begin
      m_low = 1; m_cnt = 0;
    end
    if (st && !m_ot) begin
      if (f_ok) m_hit = 0;
      else if (m_hit == OH-1) m_ot = 1;
      else m_hit++;
    end
    if (last) m_phase = ~m_phase;
  endtask

  // driver: one full window; non-final ticks carry inverted flags (R2)
  task automatic run_window(input logic f_bi, input logic f_bo, input logic f_ok, input string tag);
    item_t it;
    logic was_mains;
    was_mains = !m_phase;
    m_bo = 0;
    for (int k = 0; k < W; k++) begin
      logic last;
      last = (k == W-1);
      @(negedge clk);
      tick = 1'b1;
      bi  = last ? f_bi : ~f_bi;
      bo  = last ? f_bo : ~f_bo;
      tok = last ? f_ok : ~f_ok;
      model_tick(last, f_bi, f_bo, f_ok);
      @(negedge clk);
      tick = 1'b0;
      bi = ~bi; bo = ~bo; tok = ~tok;  // off-tick noise
      if (!last) @(negedge clk);
    end
    it.biok = m_biok; it.bo = m_bo; it.ot = m_ot; it.valid = was_mains; it.tag = tag;
    q.push_back(it);
    check_req = 1'b1;
    @(negedge clk);
  endtask

  // monitor: collects brownout pulses, compares when a window closes
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bo_ev === 1'b1) bo_acc = 1'b1;
      if (check_req) begin
        item_t e;
        e = q.pop_front();
        chk(e.tag, "brownin_ok", bi_ok, e.biok);
        chk("R6", "brownout seen", bo_acc, e.bo);
        chk("R8", "ot_latch", ot, e.ot);
        chk("R3", "mains_valid", valid, e.valid);
        check_req = 1'b0;
        bo_acc = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "brownin_ok in reset", bi_ok, 1'b0);
    chk("R1", "ot in reset", ot, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1", "brownout after reset", bo_ev, 1'b0);
    chk("R1", "valid after reset", valid, 1'b0);

    run_window(0, 0, 0, "R4");   // mains low: no permission
    run_window(0, 0, 1, "R2");   // thermal good
    run_window(1, 1, 0, "R4");   // brown-in reached
    run_window(1, 1, 0, "R8");   // thermal bad 1
    run_window(0, 1, 0, "R5");   // hysteresis holds
    run_window(0, 0, 1, "R8");   // thermal good clears count
    run_window(0, 0, 1, "R6");   // low span opens
    run_window(0, 0, 0, "R2");   // thermal bad 1
    run_window(1, 1, 0, "R7");   // good sample cancels span
    run_window(0, 0, 0, "R8");   // thermal bad 2
    run_window(0, 0, 1, "R6");   // new low span
    run_window(0, 0, 0, "R8");   // thermal bad 3
    run_window(0, 0, 0, "R6");   // still low
    run_window(0, 0, 0, "R6");   // bad 4 latches; span expires here
    run_window(1, 1, 1, "R4");   // permission back
    run_window(0, 0, 1, "R9");   // latch stays despite good sample
    run_window(1, 1, 1, "R10");

    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1", "brownin_ok on reset", bi_ok, 1'b0);
    chk("R1", "ot on reset", ot, 1'b0);
    chk("R1", "valid on reset", valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_phase = 0; m_biok = 0; m_low = 0; m_ot = 0; m_cnt = 0; m_hit = 0;
    run_window(1, 1, 1, "R1");   // first window after reset is mains
    run_window(1, 1, 1, "R2");
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule